// File: doc/BRIEF.md
# Segmented DAC switch-matrix decoder

This block turns one 12-bit sample per clock into the switch-control word of a segmented current-steering converter. The four low bits drive four binary-weighted cells directly. The eight high bits form the unary segment. Their value `v` is expanded into a thermometer of 255 active steps, and each step is wired to one cell of a 16-by-16 array of unit cells.

The array is split into 16 regions of 16 sources each. Consecutive turn-on steps hop from region to region instead of filling neighbouring cells. This spreads gradient errors across the whole array.

Every switch control comes from one output register bank. The whole word therefore changes on a single sample-clock edge, one cycle after a sample is accepted. The input is a valid/ready stream that never applies back-pressure: `in_ready_o` stays high, and a sample is taken on every edge where `in_valid_i` is high. On edges where `in_valid_i` is low, the switch word keeps its last value.

Top module: `dac_seg_decoder`

## Requirements
- R1: The input word splits into a unary part, bits [11:4], with value `v`, and a binary part, bits [3:0]; the two parts are decoded independently.
- R2: After an accepted sample, exactly `v` bits of `cell_en_o` are high.
- R3: `bin_en_o` equals bits [3:0] of the accepted sample; bit i drives the cell of weight 2^i (weights 1, 2, 4, 8).
- R4: Step k (0..255) belongs to source k/16 in region k mod 16, and its cell is bit region*16+source of `cell_en_o`. Exactly the steps 0..v-1 are on. For example, v=2 turns on bits 0 and 16, and v=17 adds bit 1.
- R5: Bit 255 of `cell_en_o` (step 255) is never high; it is a dummy cell.
- R6: `cell_en_o`, `bin_en_o` and `out_valid_o` all update on the clock edge that accepts the sample, one cycle of latency, and `out_valid_o` is high for the cycle after each accepted sample.
- R7: On an edge where `in_valid_i` is low, `cell_en_o` and `bin_en_o` keep their values and `out_valid_o` goes low.
- R8: While `rst_n_i` is low at a clock edge, all outputs are cleared to zero on that edge, which is the code-zero word; reset wins over `in_valid_i`.
- R9: `in_ready_o` is always high, so a new sample can be accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Sample present on `in_code_i` |
| in_ready_o | output | 1 | Always high; the block takes one sample per clock |
| in_code_i | input | 12 | Sample code, unary segment on top |
| out_valid_o | output | 1 | High the cycle after an accepted sample |
| cell_en_o | output | 256 | Unit-cell enables, indexed region*16+source |
| bin_en_o | output | 4 | Binary-weighted cell enables |

## Verification
The bench builds the block with its default parameters: 4 source bits, 4 region bits and 4 binary bits. These defaults give the full 256-cell array and a 4096-code space small enough to sweep completely. Each code is checked against a behavioural model that places each step by division and remainder. Back-to-back sweeping covers the hop across all 16 regions and the wrap from source n to n+1. Interleaved idle cycles, a directed two-region example and a reset asserted with a valid sample cover the hold and reset behaviour.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
  // Default geometry of the unary array and the binary segment
  localparam int DEF_SRC_BITS = 4;  // sources per region = 2**DEF_SRC_BITS
  localparam int DEF_REG_BITS = 4;  // number of regions  = 2**DEF_REG_BITS
  localparam int DEF_BIN_BITS = 4;  // binary-weighted cells
endpackage

// File: rtl/dac_therm_decoder.sv
// Step-order thermometer: step k is on when k < value.
module dac_therm_decoder #(
  parameter int VAL_W = 8,
  localparam int STEPS = 1 << VAL_W
) (
  input  logic [VAL_W-1:0] value_i,
  output logic [STEPS-1:0] step_on_o
);
  for (genvar k = 0; k < STEPS; k++) begin : g_step
    localparam logic [VAL_W-1:0] KV = VAL_W'(k);
    assign step_on_o[k] = (KV < value_i);
  end
endmodule

// File: rtl/dac_step_mapper.sv
// Places switching steps on physical cells: step s*NREG+r -> cell r*NSRC+s.
module dac_step_mapper #(
  parameter int SRC_BITS = 4,
  parameter int REG_BITS = 4,
  localparam int NSRC  = 1 << SRC_BITS,
  localparam int NREG  = 1 << REG_BITS,
  localparam int CELLS = NSRC * NREG
) (
  input  logic [CELLS-1:0] step_on_i,
  output logic [CELLS-1:0] cell_on_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign cell_on_o[r*NSRC + s] = step_on_i[s*NREG + r];
    end
  end
endmodule

// File: rtl/dac_seg_decoder.sv
module dac_seg_decoder
  import dac_seg_pkg::*;
#(
  parameter int SRC_BITS = DEF_SRC_BITS,
  parameter int REG_BITS = DEF_REG_BITS,
  parameter int BIN_BITS = DEF_BIN_BITS,
  localparam int UN_W   = SRC_BITS + REG_BITS,
  localparam int CODE_W = UN_W + BIN_BITS,
  localparam int CELLS  = 1 << UN_W
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CODE_W-1:0] in_code_i,
  output logic              out_valid_o,
  output logic [CELLS-1:0]  cell_en_o,
  output logic [BIN_BITS-1:0] bin_en_o
);
  logic [UN_W-1:0]     unary_val;
  logic [BIN_BITS-1:0] bin_val;
  logic [CELLS-1:0]    step_on;
  logic [CELLS-1:0]    cell_on;

  assign unary_val  = in_code_i[CODE_W-1:BIN_BITS];
  assign bin_val    = in_code_i[BIN_BITS-1:0];
  assign in_ready_o = 1'b1;

  dac_therm_decoder #(.VAL_W(UN_W)) u_therm (
    .value_i  (unary_val),
    .step_on_o(step_on)
  );

  dac_step_mapper #(.SRC_BITS(SRC_BITS), .REG_BITS(REG_BITS)) u_map (
    .step_on_i(step_on),
    .cell_on_o(cell_on)
  );

  // One register bank for every switch so all change on the same edge
  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cell_en_o   <= '0;
      bin_en_o    <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        cell_en_o <= cell_on;
        bin_en_o  <= bin_val;
      end
    end
  end

  AST_UNARY_COUNT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    in_valid_i |=> ($countones(cell_en_o) == int'($past(in_code_i[CODE_W-1:BIN_BITS])))); // R2
  AST_BIN_PASS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    in_valid_i |=> (bin_en_o == $past(in_code_i[BIN_BITS-1:0]))); // R3
  AST_FIRST_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    in_valid_i |=> (cell_en_o[0] == ($past(in_code_i[CODE_W-1:BIN_BITS]) != '0))); // R4
  AST_DUMMY_OFF: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    out_valid_o |-> !cell_en_o[CELLS-1]); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !in_valid_i |=> ($stable(cell_en_o) && $stable(bin_en_o) && !out_valid_o)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_n_i |=> (cell_en_o == '0 && bin_en_o == '0 && !out_valid_o)); // R8
endmodule

// File: tb/dac_seg_decoder_bench.sv
`timescale 1ns/1ps
module dac_seg_decoder_bench;
  localparam int CODE_W = 12;
  localparam int CELLS  = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, in_valid, in_ready, out_valid;
  logic [CODE_W-1:0] in_code;
  logic [CELLS-1:0]  cell_en;
  logic [3:0]        bin_en;

  dac_seg_decoder u_dac_seg_decoder (
    .clk_i(clk), .rst_n_i(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_code_i(in_code), .out_valid_o(out_valid), .cell_en_o(cell_en), .bin_en_o(bin_en)
  );

  int n_chk = 0, n_fail = 0;
  bit compare_on = 0, done = 0;

  logic [CELLS-1:0] exp_cell;
  logic [3:0]       exp_bin;
  logic             exp_ov;
  int               exp_cnt;

  function automatic logic [CELLS-1:0] ref_cells(int v);
    logic [CELLS-1:0] r = '0;
    for (int k = 0; k < v; k++) r[(k % 16) * 16 + k / 16] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [CELLS-1:0] act, logic [CELLS-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model: state updated on each edge from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_cell <= '0; exp_bin <= '0; exp_ov <= 1'b0; exp_cnt <= 0;
    end else begin
      exp_ov <= in_valid;
      if (in_valid) begin
        exp_cell <= ref_cells(int'(in_code[11:4]));
        exp_bin  <= in_code[3:0];
        exp_cnt  <= int'(in_code[11:4]);
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (compare_on) begin
      check($countones(cell_en) == exp_cnt, "R2", "popcount", CELLS'($countones(cell_en)), CELLS'(exp_cnt));
      check(cell_en == exp_cell, "R4", "cell map", cell_en, exp_cell);
      check(bin_en == exp_bin, "R3", "binary bits", CELLS'(bin_en), CELLS'(exp_bin));
      check(!cell_en[CELLS-1], "R5", "dummy cell", CELLS'(cell_en[CELLS-1]), '0);
      check(out_valid == exp_ov, "R6", "out_valid", CELLS'(out_valid), CELLS'(exp_ov));
      check(in_ready == 1'b1, "R9", "in_ready", CELLS'(in_ready), CELLS'(1));
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(cell_en == '0 && bin_en == '0 && !out_valid, "R8", "reset state", cell_en, '0);
    compare_on = 1;
    rst_n = 1'b1;
    // R1 R2 R3 R4 R6 R9: full sweep, one code per clock
    for (int c = 0; c < 4096; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_code = CODE_W'(c);
    end
    // R7: idle cycles with changing code must not disturb outputs
    for (int i = 0; i < 96; i++) begin
      @(negedge clk);
      in_valid = (i % 3 == 0);
      in_code  = CODE_W'(i * 677 + 13);
    end
    // R4: directed placement, v = 17
    @(negedge clk);
    in_valid = 1'b1; in_code = 12'h110;
    @(negedge clk);
    in_valid = 1'b0; in_code = 12'hFFF;
    check(cell_en[0] && cell_en[16] && cell_en[1] && !cell_en[2] && !cell_en[17],
          "R4", "v=17 placement", cell_en, ref_cells(17));
    @(negedge clk);
    check(cell_en == ref_cells(17), "R7", "hold after idle", cell_en, ref_cells(17));
    // R8: reset wins over a valid sample
    in_valid = 1'b1; in_code = 12'hABC;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cell_en == '0 && bin_en == '0 && !out_valid, "R8", "mid-run reset", cell_en, '0);
    rst_n = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    compare_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule